// File: doc/BRIEF.md
# Power-Good / Power-Down Sequencer

This block watches a single shared control input that serves two purposes. Its first rising level after reset means that supplies are good. Every later level means power-down (low) or wake (high). The input is synchronized and filtered on the reference clock. A state machine then steps through four phases: waiting for power-good, stabilization, run, and power-down. On the first qualified high level it captures four configuration straps: two frequency-select bits, the debug-pair mode and the shared-pin function. It then holds all clocks off for a stabilization interval before it raises the global run enable.

On each wake from power-down, a configuration bit selects between two restarts. A warm restart keeps the captured straps. A cold restart captures the straps again. In both cases the stabilization interval runs again. During power-down, the differential outputs are held low (run enable low) and the single-ended outputs go to high impedance. The one exception is the shared pin: it keeps running when it is strapped as a 25 MHz output and wake-on-LAN is enabled.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: Out of reset, `run_en`, `se_oe`, `shared_oe` and `stab_done` are 0 and all latched strap outputs are 0.
- R2: The raw input passes through SYNC_STAGES flops and must then differ from the filtered level for DEB_CYCLES consecutive cycles before the filtered level follows it. A pulse of DEB_CYCLES-1 cycles has no effect.
- R3: The first qualified high level captures `strap_in` SYNC_STAGES+DEB_CYCLES+1 cycles after the raw rise. Strap fields: bit 3 → `fs_sel[1]`, bit 2 → `fs_sel[0]`, bit 1 → `itp_cpu` (1 = CPU debug clock, 0 = SRC clock), bit 0 → `shared_pci` (1 = 33.3 MHz PCI, 0 = 25 MHz).
- R4: `stab_done` rises STAB_CYCLES cycles after the capture cycle, and `run_en` rises one cycle after that.
- R5: When the raw input goes low while running, `run_en` and `se_oe` fall SYNC_STAGES+DEB_CYCLES+1 cycles after the raw fall, and `stab_done` falls one cycle later.
- R6: When `warm_wake`=1, leaving power-down keeps the previously latched straps and repeats the full stabilization interval before `run_en`.
- R7: When `warm_wake`=0, leaving power-down captures `strap_in` again.
- R8: Changes on `strap_in` while running have no effect on the latched strap outputs.
- R9: In power-down, `shared_oe` is 1 exactly when `wol_en`=1 and `shared_pci`=0. Otherwise it is 0. `wol_en` acts combinationally.
- R10: A low level arriving during stabilization aborts to power-down, and `run_en` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pg_pd_raw | input | 1 | Shared power-good / power-down level, asynchronous |
| strap_in | input | 4 | Raw configuration straps |
| warm_wake | input | 1 | 1 = warm wake keeps straps, 0 = cold wake relatches them |
| wol_en | input | 1 | Wake-on-LAN enable |
| run_en | output | 1 | Global run enable; 0 also holds differential outputs low |
| se_oe | output | 1 | Single-ended output enable; 0 = high impedance |
| shared_oe | output | 1 | Enable for the shared 25 MHz / PCI pin |
| stab_done | output | 1 | Stabilization interval complete |
| fs_sel | output | 2 | Latched frequency-select straps |
| itp_cpu | output | 1 | Latched debug-pair mode |
| shared_pci | output | 1 | Latched shared-pin function |

## Verification
Every result is timed from the clock edge after the bench changes `pg_pd_raw` on a falling edge. The latency totals are as follows:
- Strap capture and the power-down drop land SYNC_STAGES+DEB_CYCLES+1 edges after the change.
- `stab_done` lands STAB_CYCLES edges later still, and `run_en` one edge after that.
- The power-down fall of `stab_done` comes one edge after `run_en` falls.

The bench counts rising edges until each output changes and compares the count exactly against these totals. It samples 1 ns after each edge. Conditions with no timing, such as the wake-on-LAN enable and ignored straps, are sampled after settling and before the next stimulus.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [1:0] {
    ST_WAIT_PG = 2'd0,
    ST_STAB    = 2'd1,
    ST_RUN     = 2'd2,
    ST_PDN     = 2'd3
  } seq_state_e;

  localparam int STRAP_W   = 4;
  localparam int STRAP_FSH = 3;
  localparam int STRAP_FSL = 2;
  localparam int STRAP_ITP = 1;
  localparam int STRAP_SEL = 0;
endpackage

// File: rtl/pg_filter.sv
module pg_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_CYCLES  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic level_o
);
  localparam int DW = $clog2(DEB_CYCLES + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [DW-1:0]          cnt_q, cnt_d;
  logic                   filt_q, filt_d;
  logic                   sync_w;

  assign sync_w  = sync_q[SYNC_STAGES-1];
  assign level_o = filt_q;

  // synchronizer chain
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_in};
  end

  // filter next-state
  always_comb begin
    filt_d = filt_q;
    cnt_d  = '0;
    if (sync_w != filt_q) begin
      if (cnt_q == DW'(DEB_CYCLES - 1)) filt_d = sync_w;
      else                              cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      filt_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      filt_q <= filt_d;
    end
  end

  // R2: the filtered level only ever moves to the synchronized value
  assert_filter_follows_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_q != $past(filt_q)) |-> (filt_q == $past(sync_w)));
endmodule

// File: rtl/stab_timer.sv
module stab_timer #(
  parameter int STAB_CYCLES = 25773
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic done_o
);
  localparam int CW = $clog2(STAB_CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;

  assign done_o = done_q;

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    if (clr) begin
      cnt_d  = '0;
      done_d = 1'b0;
    end else if (en && !done_q) begin
      if (cnt_q == CW'(STAB_CYCLES - 1)) done_d = 1'b1;
      else                              cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  // R4: completion can only come out of an active count
  assert_done_from_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(en));
endmodule

// File: rtl/strap_latch.sv
module strap_latch
  import pwr_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               capture,
  input  logic [STRAP_W-1:0] strap_in,
  output logic [STRAP_W-1:0] strap_q
);
  logic [STRAP_W-1:0] hold_q;

  assign strap_q = hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (capture) hold_q <= strap_in;
  end
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import pwr_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       level,
  input  logic       tmr_done,
  input  logic       warm_wake,
  output seq_state_e state_o,
  output logic       capture,
  output logic       tmr_clr,
  output logic       tmr_en
);
  seq_state_e state_q, state_d;

  assign state_o = state_q;
  assign tmr_clr = (state_q == ST_PDN) || (state_q == ST_WAIT_PG);
  assign tmr_en  = (state_q == ST_STAB);

  always_comb begin
    state_d = state_q;
    capture = 1'b0;
    unique case (state_q)
      ST_WAIT_PG: if (level) begin
        state_d = ST_STAB;
        capture = 1'b1;
      end
      ST_STAB: begin
        if (!level)        state_d = ST_PDN;
        else if (tmr_done) state_d = ST_RUN;
      end
      ST_RUN: if (!level) state_d = ST_PDN;
      ST_PDN: if (level) begin
        state_d = ST_STAB;
        capture = !warm_wake;
      end
      default: state_d = ST_WAIT_PG;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_WAIT_PG;
    else        state_q <= state_d;
  end

  // R4: running implies the stabilization interval has elapsed
  assert_run_needs_stab_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |-> tmr_done);
  // R10: a low level during stabilization never leads straight to run
  assert_abort_to_pdn_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_STAB) && !level) |=> (state_q == ST_PDN));
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_CYCLES  = 4,
  parameter int STAB_CYCLES = 25773
) (
  input  logic       clk_ref,
  input  logic       rst_n,
  input  logic       pg_pd_raw,
  input  logic [3:0] strap_in,
  input  logic       warm_wake,
  input  logic       wol_en,
  output logic       run_en,
  output logic       se_oe,
  output logic       shared_oe,
  output logic       stab_done,
  output logic [1:0] fs_sel,
  output logic       itp_cpu,
  output logic       shared_pci
);
  logic               level;
  logic               capture, tmr_clr, tmr_en, tmr_done;
  logic [STRAP_W-1:0] strap_q;
  seq_state_e         state;
  logic               wol_keep;

  pg_filter #(.SYNC_STAGES(SYNC_STAGES), .DEB_CYCLES(DEB_CYCLES)) u_filter (
    .clk(clk_ref), .rst_n(rst_n), .raw_in(pg_pd_raw), .level_o(level));

  seq_fsm u_fsm (
    .clk(clk_ref), .rst_n(rst_n), .level(level), .tmr_done(tmr_done),
    .warm_wake(warm_wake), .state_o(state), .capture(capture),
    .tmr_clr(tmr_clr), .tmr_en(tmr_en));

  stab_timer #(.STAB_CYCLES(STAB_CYCLES)) u_timer (
    .clk(clk_ref), .rst_n(rst_n), .clr(tmr_clr), .en(tmr_en), .done_o(tmr_done));

  strap_latch u_straps (
    .clk(clk_ref), .rst_n(rst_n), .capture(capture),
    .strap_in(strap_in), .strap_q(strap_q));

  assign fs_sel     = {strap_q[STRAP_FSH], strap_q[STRAP_FSL]};
  assign itp_cpu    = strap_q[STRAP_ITP];
  assign shared_pci = strap_q[STRAP_SEL];

  assign wol_keep   = (state == ST_PDN) && wol_en && !strap_q[STRAP_SEL];
  assign run_en     = (state == ST_RUN);
  assign se_oe      = (state == ST_RUN);
  assign shared_oe  = (state == ST_RUN) || wol_keep;
  assign stab_done  = tmr_done;

  // R8: straps are frozen while running
  assert_straps_frozen_R8: assert property (@(posedge clk_ref) disable iff (!rst_n)
    run_en |=> $stable(strap_q));
  // R9: shared pin alive outside run only for wake-on-LAN at 25 MHz
  assert_wol_only_R9: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (shared_oe && !run_en) |-> (wol_en && !shared_pci));
  // R5: single-ended outputs are never enabled while stopped
  assert_pd_outputs_off_R5: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !run_en |-> !se_oe);
endmodule

// File: tb/pwr_seq_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_seq_ctrl_tb;
  localparam int SYNC = 2;
  localparam int DEB  = 4;
  localparam int LIM  = 16;
  localparam int T_IN   = SYNC + DEB + 1;  // capture / power-down entry
  localparam int T_DONE = T_IN + LIM;      // stab_done rise
  localparam int T_RUN  = T_DONE + 1;      // run_en rise

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pg_pd_raw = 1'b0;
  logic [3:0] strap_in = 4'b0000;
  logic warm_wake = 1'b1;
  logic wol_en = 1'b0;
  logic run_en, se_oe, shared_oe, stab_done, itp_cpu, shared_pci;
  logic [1:0] fs_sel;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pwr_seq_ctrl #(.SYNC_STAGES(SYNC), .DEB_CYCLES(DEB), .STAB_CYCLES(LIM)) u_dut (
    .clk_ref(clk), .rst_n(rst_n), .pg_pd_raw(pg_pd_raw), .strap_in(strap_in),
    .warm_wake(warm_wake), .wol_en(wol_en), .run_en(run_en), .se_oe(se_oe),
    .shared_oe(shared_oe), .stab_done(stab_done), .fs_sel(fs_sel),
    .itp_cpu(itp_cpu), .shared_pci(shared_pci));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic sig(input int sel);
    case (sel)
      0:       return run_en;
      1:       return stab_done;
      2:       return se_oe;
      default: return shared_oe;
    endcase
  endfunction

  task automatic measure(input int sel, input logic val, output int n);
    n = 0;
    do begin
      @(posedge clk); #1; n++;
    end while (sig(sel) != val && n < 500);
  endtask

  task automatic drive_raw(input logic v);
    @(negedge clk); pg_pd_raw = v;
  endtask

  function automatic logic [3:0] straps_out();
    return {fs_sel, itp_cpu, shared_pci};
  endfunction

  task automatic t_reset();
    #1;
    check(!run_en && !se_oe && !shared_oe && !stab_done, "R1 outputs", {run_en, se_oe, shared_oe, stab_done}, 0);
    check(straps_out() == 4'b0000, "R1 straps", straps_out(), 0);
  endtask

  task automatic t_glitch();
    strap_in = 4'b1111;
    drive_raw(1'b1);
    repeat (DEB - 1) @(negedge clk);
    pg_pd_raw = 1'b0;
    repeat (40) @(posedge clk);
    #1;
    check(!stab_done && !run_en, "R2 short pulse ignored", {stab_done, run_en}, 0);
    check(straps_out() == 4'b0000, "R2 no capture", straps_out(), 0);
  endtask

  task automatic t_startup();
    int n;
    strap_in = 4'b1010;
    drive_raw(1'b1);
    measure(1, 1'b1, n);
    check(n == T_DONE, "R4 stab_done latency", n, T_DONE);
    check(!run_en, "R4 run_en still low", run_en, 0);
    measure(0, 1'b1, n);
    check(n == 1, "R4 run_en one cycle later", n, 1);
    check(straps_out() == 4'b1010, "R3 straps latched", straps_out(), 4'b1010);
    check(se_oe && shared_oe, "R5 outputs on in run", {se_oe, shared_oe}, 3);
  endtask

  task automatic t_strap_ignore();
    @(negedge clk); strap_in = 4'b0101;
    repeat (10) @(posedge clk);
    #1;
    check(straps_out() == 4'b1010, "R8 straps ignored in run", straps_out(), 4'b1010);
  endtask

  task automatic t_powerdown(input logic exp_keep);
    int n;
    wol_en = 1'b0;
    drive_raw(1'b0);
    measure(0, 1'b0, n);
    check(n == T_IN, "R5 run_en fall latency", n, T_IN);
    check(!se_oe && !shared_oe, "R5 outputs off", {se_oe, shared_oe}, 0);
    measure(1, 1'b0, n);
    check(n == 1, "R5 stab_done fall", n, 1);
    @(negedge clk); wol_en = 1'b1; #1;
    check(shared_oe == exp_keep, "R9 shared pin with wol", shared_oe, exp_keep);
    check(!se_oe, "R9 other outputs stay off", se_oe, 0);
    @(negedge clk); wol_en = 1'b0; #1;
    check(!shared_oe, "R9 shared pin without wol", shared_oe, 0);
  endtask

  task automatic t_wake(input logic warm, input logic [3:0] new_straps, input logic [3:0] exp_straps);
    int n;
    warm_wake = warm;
    strap_in  = new_straps;
    drive_raw(1'b1);
    measure(0, 1'b1, n);
    check(n == T_RUN, warm ? "R6 warm wake run latency" : "R7 cold wake run latency", n, T_RUN);
    check(straps_out() == exp_straps, warm ? "R6 straps kept" : "R7 straps relatched", straps_out(), exp_straps);
  endtask

  task automatic t_abort();
    int highs = 0;
    warm_wake = 1'b1;
    drive_raw(1'b1);
    repeat (T_IN + 4) @(negedge clk);
    pg_pd_raw = 1'b0;
    for (int i = 0; i < 60; i++) begin
      @(posedge clk); #1;
      if (run_en || stab_done) highs++;
    end
    check(highs == 0, "R10 abort keeps run off", highs, 0);
    check(!se_oe, "R10 outputs off", se_oe, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_glitch();
    t_startup();
    t_strap_ignore();
    t_powerdown(1'b1);                     // shared pin strapped 25 MHz
    t_wake(1'b1, 4'b0111, 4'b1010);        // warm
    t_powerdown(1'b1);
    t_wake(1'b0, 4'b0111, 4'b0111);        // cold
    t_powerdown(1'b0);                     // shared pin strapped PCI
    t_abort();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule